// File: doc/BRIEF.md
# Transparent Translation Range Matcher

This block sits beside the page-translation cache of one access stream and decides, each cycle, whether the current logical address falls in a region that is mapped one-to-one. It holds two programmable window registers. Each window names an 8-bit tag for the top address byte and a per-bit ignore mask, so a window covers anywhere from 16 MB up to the whole 4 GB space. A window can be restricted to user accesses or to supervisor accesses, and it can be write-protected.

When a window hits, `ttHit` tells the translation logic to bypass its cache: the physical address is the logical address, the cache lookup is not used and no entry is loaded. The winning window also supplies a two-bit cache-mode attribute. A write into a write-protected window raises `protFault`, and the access is still reported as a transparent hit. The lookup is combinational on the current address and mode. A register write takes effect on the next clock edge.

Top module: `ttr_matcher`

## Requirements
- R1: After reset both windows are disabled, and `ttHit`, `protFault`, `cacheMode` and `paddr` are all zero for any input.
- R2: When `cfgWe` is high on a rising edge, `cfgData` is stored in window `cfgSel`. The lookup sees the new value from that edge on, and not before it. Field layout: [21] enable, [20:19] mode, [18] write-protect, [17:16] cache mode, [15:8] tag, [7:0] ignore mask.
- R3: An enabled window matches when, for every bit k (0..7) whose ignore-mask bit is 0, `laddr[24+k]` equals tag bit k. Address bits 23..0 never affect the match. An all-ones mask matches every address and an all-zero mask gives a 16 MB region.
- R4: A window whose enable bit is 0 never matches, whatever its other fields hold.
- R5: Mode field 2'b00 matches only when `superMode` is 0 (user), 2'b01 matches only when `superMode` is 1 (supervisor), and 2'b10 or 2'b11 matches in either mode.
- R6: On a hit `paddr` equals `laddr`. With no hit `paddr` is zero.
- R7: When both windows match, window 0 supplies `cacheMode` and the write-protect decision.
- R8: `protFault` is 1 exactly when there is a hit, `isWrite` is 1 and the winning window is write-protected, and `ttHit` stays 1 in that case. A read of a protected window gives no fault.
- R9: With no hit, `cacheMode` and `protFault` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Window register write strobe |
| cfgSel | input | 1 | Index of the window to write |
| cfgData | input | 22 | Window register write value |
| laddr | input | 32 | Logical address of the access |
| superMode | input | 1 | 1 for a supervisor access, 0 for a user access |
| isWrite | input | 1 | 1 for a write access, 0 for a read |
| ttHit | output | 1 | Transparent hit; overrides the translation cache |
| paddr | output | 32 | Physical address (equal to `laddr` on a hit) |
| cacheMode | output | 2 | Cache-mode attribute of the winning window |
| protFault | output | 1 | Write to a write-protected window |

## Verification
The masked compare is tried with random tags and masks against addresses built from each window's own tag with random bits flipped. This separates a mask bit that is honoured from one that is ignored, and shows that the low 24 bits do not matter. Directed cases cover the edge masks (all-zero and all-ones), every mode encoding in both privilege levels, and disabled windows with otherwise matching fields. They also cover overlapping windows with different attributes, which exposes a reversed priority, and reads against writes into protected windows. Register writes are checked both in the cycle the strobe is asserted and after the edge, so an early or a lost update shows up.

// File: rtl/ttr_pkg.sv
package ttr_pkg;
  // number of windows per access stream and width of the compared top field
  localparam int TT_REGS = 2;
  localparam int TAG_W   = 8;
  localparam int SEL_W   = (TT_REGS > 1) ? $clog2(TT_REGS) : 1;

  // mode field encodings
  localparam logic [1:0] MODE_USER  = 2'b00;
  localparam logic [1:0] MODE_SUPER = 2'b01;

  typedef struct packed {
    logic             en;
    logic [1:0]       mode;
    logic             wp;
    logic [1:0]       cmode;
    logic [TAG_W-1:0] tag;
    logic [TAG_W-1:0] mask;
  } ttr_cfg_t;

  localparam int CFG_W = $bits(ttr_cfg_t);

  // strobes from control to datapath
  typedef struct packed {
    logic [TT_REGS-1:0] load;
    logic [TT_REGS-1:0] pick;
  } ttr_strobe_t;
endpackage

// File: rtl/ttr_ctrl.sv
module ttr_ctrl
  import ttr_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [SEL_W-1:0]   cfgSel,
  input  logic [TT_REGS-1:0] matchVec,
  output ttr_strobe_t        strobe
);

  logic [TT_REGS-1:0] loadVec;
  logic [TT_REGS-1:0] pickVec;
  logic               found;

  // write decode: one load strobe per window
  always_comb begin
    loadVec = '0;
    for (int i = 0; i < TT_REGS; i++) begin
      if (cfgWe && (cfgSel == SEL_W'(i))) loadVec[i] = 1'b1;
    end
  end

  // fixed priority: lowest window index wins
  always_comb begin
    pickVec = '0;
    found   = 1'b0;
    for (int i = 0; i < TT_REGS; i++) begin
      if (matchVec[i] && !found) begin
        pickVec[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  assign strobe.load = loadVec;
  assign strobe.pick = pickVec;

  // R7: at most one window drives the attributes
  p_pick_onehot_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.pick));

  // R7: the chosen window must actually match
  p_pick_subset_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pick & ~matchVec) == '0);

  // R7: window 0 wins whenever it matches
  p_pick_first_r7: assert property (@(posedge clk) disable iff (!rstN)
    matchVec[0] |-> strobe.pick[0]);

endmodule

// File: rtl/ttr_datapath.sv
module ttr_datapath
  import ttr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [CFG_W-1:0]   cfgData,
  input  logic               cfgWe,
  input  logic [SEL_W-1:0]   cfgSel,
  input  logic [ADDR_W-1:0]  laddr,
  input  logic               superMode,
  input  logic               isWrite,
  input  ttr_strobe_t        strobe,
  output logic [TT_REGS-1:0] matchVec,
  output logic               ttHit,
  output logic [ADDR_W-1:0]  paddr,
  output logic [1:0]         cacheMode,
  output logic               protFault
);

  localparam int TAG_LSB = ADDR_W - TAG_W;

  ttr_cfg_t         cfgReg [TT_REGS];
  logic [TAG_W-1:0] addrTag;
  logic             anyHit;
  logic [1:0]       selCmode;
  logic             selWp;

  assign addrTag = laddr[ADDR_W-1:TAG_LSB];

  for (genvar g = 0; g < TT_REGS; g++) begin : g_win
    logic modeOk;
    logic tagOk;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               cfgReg[g] <= '0;
      else if (strobe.load[g]) cfgReg[g] <= ttr_cfg_t'(cfgData);
    end

    always_comb begin
      unique case (cfgReg[g].mode)
        MODE_USER:  modeOk = !superMode;
        MODE_SUPER: modeOk = superMode;
        default:    modeOk = 1'b1;
      endcase
    end

    assign tagOk       = ((addrTag ^ cfgReg[g].tag) & ~cfgReg[g].mask) == '0;
    assign matchVec[g] = cfgReg[g].en && modeOk && tagOk;
  end

  // attribute mux driven by the one-hot pick strobe
  always_comb begin
    anyHit   = 1'b0;
    selCmode = '0;
    selWp    = 1'b0;
    for (int i = 0; i < TT_REGS; i++) begin
      if (strobe.pick[i]) begin
        anyHit   = 1'b1;
        selCmode = selCmode | cfgReg[i].cmode;
        selWp    = selWp | cfgReg[i].wp;
      end
    end
  end

  assign ttHit     = anyHit;
  assign paddr     = anyHit ? laddr : '0;
  assign cacheMode = selCmode;
  assign protFault = anyHit && isWrite && selWp;

  // R2: a write lands in the selected window on the strobe edge
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |=> cfgReg[$past(cfgSel)] == ttr_cfg_t'($past(cfgData)));

  // R4: writing a cleared enable removes the window from matching
  p_disable_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && !cfgData[CFG_W-1]) |=> !matchVec[$past(cfgSel)]);

  // R6: a hit only appears when some window matches
  p_hit_needs_match_r6: assert property (@(posedge clk) disable iff (!rstN)
    ttHit |-> (matchVec != '0));

  // R8: a fault is always a write that still reports a hit
  p_fault_write_hit_r8: assert property (@(posedge clk) disable iff (!rstN)
    protFault |-> (isWrite && ttHit));

endmodule

// File: rtl/ttr_matcher.sv
module ttr_matcher
  import ttr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [SEL_W-1:0]  cfgSel,
  input  logic [CFG_W-1:0]  cfgData,
  input  logic [ADDR_W-1:0] laddr,
  input  logic              superMode,
  input  logic              isWrite,
  output logic              ttHit,
  output logic [ADDR_W-1:0] paddr,
  output logic [1:0]        cacheMode,
  output logic              protFault
);

  ttr_strobe_t        strobe;
  logic [TT_REGS-1:0] matchVec;

  ttr_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWe    (cfgWe),
    .cfgSel   (cfgSel),
    .matchVec (matchVec),
    .strobe   (strobe)
  );

  ttr_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cfgData   (cfgData),
    .cfgWe     (cfgWe),
    .cfgSel    (cfgSel),
    .laddr     (laddr),
    .superMode (superMode),
    .isWrite   (isWrite),
    .strobe    (strobe),
    .matchVec  (matchVec),
    .ttHit     (ttHit),
    .paddr     (paddr),
    .cacheMode (cacheMode),
    .protFault (protFault)
  );

  // R9: attributes stay quiet when nothing hits
  p_quiet_miss_r9: assert property (@(posedge clk) disable iff (!rstN)
    !ttHit |-> (cacheMode == 2'b00 && !protFault && paddr == '0));

endmodule

// File: tb/tb_ttr_matcher.sv
module tb_ttr_matcher;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [0:0]  cfgSel = '0;
  logic [21:0] cfgData = '0;
  logic [31:0] laddr = '0;
  logic        superMode = 1'b0;
  logic        isWrite = 1'b0;
  logic        ttHit;
  logic [31:0] paddr;
  logic [1:0]  cacheMode;
  logic        protFault;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [21:0] model [2];

  always #2.5 clk = ~clk;

  ttr_matcher dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .laddr(laddr), .superMode(superMode), .isWrite(isWrite),
    .ttHit(ttHit), .paddr(paddr), .cacheMode(cacheMode), .protFault(protFault)
  );

  // layout: [21] en, [20:19] mode, [18] wp, [17:16] cmode, [15:8] tag, [7:0] mask
  function automatic logic [21:0] mkCfg(logic en, logic [1:0] mode, logic wp,
                                        logic [1:0] cm, logic [7:0] tag, logic [7:0] mask);
    return {en, mode, wp, cm, tag, mask};
  endfunction

  function automatic logic winMatch(logic [21:0] c, logic [31:0] a, logic sup);
    logic modeOk;
    modeOk = c[20] ? 1'b1 : (c[19] == sup);
    return c[21] && modeOk && (((a[31:24] ^ c[15:8]) & ~c[7:0]) == 8'h00);
  endfunction

  // expected {ttHit, protFault, cacheMode, paddr}
  function automatic logic [35:0] expOut(logic [31:0] a, logic sup, logic wr);
    for (int i = 0; i < 2; i++) begin
      if (winMatch(model[i], a, sup))
        return {1'b1, wr & model[i][18], model[i][17:16], a};
    end
    return 36'd0;
  endfunction

  task automatic chk(string req, logic [35:0] exp);
    logic [35:0] act;
    act = {ttHit, protFault, cacheMode, paddr};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h (addr %h sup %0b wr %0b)",
               req, act, exp, laddr, superMode, isWrite);
    end
  endtask

  task automatic writeCfg(int idx, logic [21:0] val);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = idx[0]; cfgData = val;
    @(negedge clk);
    cfgWe = 1'b0;
    model[idx] = val;
  endtask

  task automatic probe(string req, logic [31:0] a, logic sup, logic wr);
    @(negedge clk);
    laddr = a; superMode = sup; isWrite = wr;
    #1;
    chk(req, expOut(a, sup, wr));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] tg;
    logic [7:0] mk;
    logic [31:0] a;
    void'($urandom(32'd2024));
    model[0] = '0; model[1] = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", 36'd0);
    @(negedge clk); rstN = 1'b1;
    probe("R1", 32'hFFFF_FFFF, 1'b1, 1'b1);
    probe("R1", 32'h0000_0000, 1'b0, 1'b0);

    // R2: value not visible during the strobe cycle, visible after the edge
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = 1'b0; cfgData = mkCfg(1, 2'b10, 0, 2'b01, 8'h40, 8'h00);
    laddr = 32'h4012_3456; superMode = 0; isWrite = 0;
    #1; chk("R2", 36'd0);
    @(negedge clk); cfgWe = 1'b0; model[0] = mkCfg(1, 2'b10, 0, 2'b01, 8'h40, 8'h00);
    #1; chk("R2", expOut(laddr, 0, 0));

    // R3: 16 MB window, low bits ignored, neighbour misses
    probe("R3", 32'h40FF_FFFF, 1, 0);
    probe("R3", 32'h4100_0000, 1, 0);
    probe("R3", 32'h3FFF_FFFF, 0, 0);
    // R3: full-space window
    writeCfg(0, mkCfg(1, 2'b11, 0, 2'b10, 8'h00, 8'hFF));
    probe("R3", 32'hDEAD_BEEF, 0, 0);
    probe("R3", 32'h0000_0001, 1, 1);
    // R3: partial mask
    writeCfg(0, mkCfg(1, 2'b10, 0, 2'b11, 8'hA0, 8'h0F));
    probe("R3", 32'hAF00_0000, 0, 0);
    probe("R3", 32'hB000_0000, 0, 0);

    // R4: disabled window with matching fields
    writeCfg(0, mkCfg(0, 2'b10, 1, 2'b11, 8'h00, 8'hFF));
    probe("R4", 32'h1234_5678, 0, 1);
    probe("R4", 32'hFFFF_0000, 1, 0);

    // R5: mode encodings
    writeCfg(0, mkCfg(1, 2'b00, 0, 2'b01, 8'h20, 8'h00));
    probe("R5", 32'h2000_0000, 0, 0);
    probe("R5", 32'h2000_0000, 1, 0);
    writeCfg(0, mkCfg(1, 2'b01, 0, 2'b01, 8'h20, 8'h00));
    probe("R5", 32'h2000_0000, 0, 0);
    probe("R5", 32'h2000_0000, 1, 0);
    writeCfg(0, mkCfg(1, 2'b11, 0, 2'b01, 8'h20, 8'h00));
    probe("R5", 32'h2000_0000, 0, 0);
    probe("R5", 32'h2000_0000, 1, 0);

    // R6 / R9: hit passes address, miss gives zeros
    probe("R6", 32'h20AB_CDEF, 1, 0);
    probe("R9", 32'h21AB_CDEF, 1, 1);

    // R7: overlapping windows, window 0 wins
    writeCfg(0, mkCfg(1, 2'b10, 0, 2'b01, 8'h80, 8'h7F));
    writeCfg(1, mkCfg(1, 2'b10, 1, 2'b10, 8'h80, 8'h0F));
    probe("R7", 32'h8300_0000, 0, 1);
    probe("R7", 32'hF000_0000, 1, 1);
    // window 1 alone where window 0 misses
    writeCfg(0, mkCfg(1, 2'b01, 0, 2'b01, 8'h80, 8'h7F));
    probe("R7", 32'h8300_0000, 0, 1);

    // R8: protected window, read vs write
    writeCfg(0, mkCfg(1, 2'b10, 1, 2'b11, 8'h55, 8'h00));
    probe("R8", 32'h5500_1000, 0, 1);
    probe("R8", 32'h5500_1000, 0, 0);
    probe("R8", 32'h5600_1000, 0, 1);

    // random mix
    for (int n = 0; n < 400; n++) begin
      if (n % 20 == 0) begin
        for (int w = 0; w < 2; w++) begin
          mk = $urandom_range(0, 3) == 0 ? 8'h00 : 8'($urandom) & 8'($urandom);
          tg = 8'($urandom);
          writeCfg(w, mkCfg($urandom_range(0, 7) != 0, 2'($urandom), 1'($urandom),
                            2'($urandom), tg, mk));
        end
      end
      a = $urandom;
      if ($urandom_range(0, 2) != 0) begin
        int w;
        w = $urandom_range(0, 1);
        a[31:24] = model[w][15:8] ^ (8'($urandom) & 8'($urandom) & 8'($urandom));
      end
      probe("R3/R5/R7/R8 random", a, 1'($urandom), 1'($urandom));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule